// File: doc/BRIEF.md
# Flash Toggle-Status Poll Controller

This block runs on the host side of a parallel flash device. It decides how an embedded program or erase operation ended by reading the device's status byte again and again. After a start pulse it latches a polling address and issues byte reads through a request/acknowledge handshake. It compares pairs of consecutive reads and reports a result code together with a one-cycle done pulse. For a program, the address given is the programmed location. For a sector erase, it is any address inside a sector scheduled for erasure.

The block has two paths, chosen at start. On the status path, a pair in which bit 6 held still means the operation has finished. If bit 6 changed, the block looks at bit 5 of the second read. When bit 5 is clear, it polls again. When bit 5 is set, it takes one more pair, because bit 6 may stop toggling in the same cycle that bit 5 rises. If bit 6 still toggles in that pair, the device reports a failure; if not, the operation completed. On the suspend path, one pair decides from bit 2 whether the addressed sector is suspended in the middle of an erase. A host-side limit on poll pairs stops a device that never settles. On either kind of timeout, the block can first issue a return-to-read reset command through a second handshake.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, busy, done, rd_req and cmd_req are low and result is 0.
- R2: Every read request carries the address latched at start. rd_req stays high until rd_ack, and no read is requested while idle.
- R3: On the status path, a pair whose bit 6 values are equal ends the operation with result 1 (complete).
- R4: On the status path, a pair with bit 6 toggled and bit 5 clear (second read) starts another pair.
- R5: On the status path, a toggled pair with bit 5 set is followed by exactly one recheck pair. If bit 6 toggles in the recheck pair, the result is 2 (device timeout); otherwise it is 1.
- R6: On the suspend path (mode=1), exactly one pair is read. Bit 2 toggled gives result 4 (suspended); bit 2 equal gives result 5 (not suspended). Bit 6 has no effect on this path.
- R7: When MAX_POLLS pairs have been read on the status path and each was toggled with bit 5 clear, the result is 3 (host timeout), after exactly 2*MAX_POLLS reads.
- R8: When reset_on_error was high at start and the result is 2 or 3, cmd_req is raised and held until cmd_ack before done. No other outcome raises cmd_req.
- R9: done is a one-cycle pulse. result holds its value from done until a later operation finishes, and busy is high from the cycle after start until done.
- R10: A start pulse while busy is ignored. The latched address, the mode and the outcome of the operation in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| mode | input | 1 | 0 = program/erase status path, 1 = suspend test |
| reset_on_error | input | 1 | Issue reset command on results 2 or 3 |
| poll_addr | input | AW | Polling address |
| rd_req | output | 1 | Status read request |
| rd_addr | output | AW | Address of the read |
| rd_ack | input | 1 | Read completed, rd_data valid this cycle |
| rd_data | input | 8 | Status byte |
| cmd_req | output | 1 | Reset command request |
| cmd_ack | input | 1 | Reset command accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 3 | 1 complete, 2 device timeout, 3 host timeout, 4 suspended, 5 not suspended |

## Verification
The checker watches the handshake rules on every cycle. These are: no read while idle, a held request with a stable address until acknowledge, a held command request, a single-cycle done, a result that stays put while idle, and a command only after a timeout result. Only the bench scenarios can show the decision logic. That covers which result comes from a given byte sequence, how many reads each path takes, the recheck after bit 5 rises (including the case where toggling stops at that moment), and the poll limit. The scenarios also show that a start pulse during an operation changes nothing.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int AW        = 20,
  parameter int MAX_POLLS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic          reset_on_error,
  input  logic [AW-1:0] poll_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          cmd_req,
  input  logic          cmd_ack,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  localparam logic [2:0] RES_NONE   = 3'd0;
  localparam logic [2:0] RES_DONE   = 3'd1;
  localparam logic [2:0] RES_DEVTO  = 3'd2;
  localparam logic [2:0] RES_HOSTTO = 3'd3;
  localparam logic [2:0] RES_SUSP   = 3'd4;
  localparam logic [2:0] RES_NOSUSP = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RB, S_CMD, S_FIN} state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic [7:0]    first_q;
  logic [CW-1:0] cnt_q;
  logic          recheck_q, mode_q, roe_q;
  logic [2:0]    result_q;

  wire dq6_tog = first_q[6] ^ rd_data[6];
  wire dq2_tog = first_q[2] ^ rd_data[2];
  wire dq5     = rd_data[5];

  logic       fin, again, to_recheck;
  logic [2:0] code;

  always_comb begin
    fin        = 1'b0;
    again      = 1'b0;
    to_recheck = 1'b0;
    code       = RES_DONE;
    if (mode_q) begin
      fin  = 1'b1;
      code = dq2_tog ? RES_SUSP : RES_NOSUSP;
    end else if (recheck_q) begin
      fin  = 1'b1;
      code = dq6_tog ? RES_DEVTO : RES_DONE;
    end else if (!dq6_tog) begin
      fin = 1'b1;
    end else if (dq5) begin
      to_recheck = 1'b1;
    end else if (cnt_q == LAST) begin
      fin  = 1'b1;
      code = RES_HOSTTO;
    end else begin
      again = 1'b1;
    end
  end

  wire is_err = (code == RES_DEVTO) || (code == RES_HOSTTO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      first_q   <= '0;
      cnt_q     <= '0;
      recheck_q <= 1'b0;
      mode_q    <= 1'b0;
      roe_q     <= 1'b0;
      result_q  <= RES_NONE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q    <= poll_addr;
          mode_q    <= mode;
          roe_q     <= reset_on_error;
          cnt_q     <= '0;
          recheck_q <= 1'b0;
          state     <= S_RA;
        end
        S_RA: if (rd_ack) begin
          first_q <= rd_data;
          state   <= S_RB;
        end
        S_RB: if (rd_ack) begin
          if (fin) begin
            result_q <= code;
            state    <= (is_err && roe_q) ? S_CMD : S_FIN;
          end else begin
            state <= S_RA;
            if (to_recheck) recheck_q <= 1'b1;
            if (again) cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CMD: if (cmd_ack) state <= S_FIN;
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req  = (state == S_RA) || (state == S_RB);
  assign rd_addr = addr_q;
  assign cmd_req = (state == S_CMD);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign result  = result_q;

endmodule

module toggle_poll_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          cmd_req,
  input logic          cmd_ack,
  input logic [2:0]    result
);

  a_r2_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> cmd_req);

  a_r8_cmd_only_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (result == 3'd2 || result == 3'd3));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  a_r10_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(rd_addr));

endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .cmd_req(cmd_req), .cmd_ack(cmd_ack), .result(result)
);

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;

  localparam int AW = 20;
  localparam int MP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic          reset_on_error = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [7:0]    rd_data = '0;
  logic          cmd_req;
  logic          cmd_ack = 1'b0;
  logic          busy, done;
  logic [2:0]    result;

  always #4 clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .MAX_POLLS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .reset_on_error(reset_on_error), .poll_addr(poll_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .busy(busy), .done(done),
    .result(result)
  );

  typedef struct {
    logic [2:0] code;
    int         reads;
    int         cmds;
    string      tag;
  } exp_t;

  int            checks = 0;
  int            errors = 0;
  logic [7:0]    stim[$];
  exp_t          expq[$];
  int            rd_cnt = 0;
  int            cmd_cnt = 0;
  int            done_cnt = 0;
  logic [AW-1:0] cur_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit d6, input bit d5, input bit d2);
    return {1'b0, d6, d5, 2'b00, d2, 2'b00};
  endfunction

  // read responder: one-cycle ack per request, byte from stim queue (R2 address check)
  always @(negedge clk) begin
    if (rd_req && !rd_ack) begin
      rd_ack <= 1'b1;
      rd_cnt++;
      if (rd_addr != cur_addr) begin
        checks++; errors++;
        $display("FAIL R2 address actual=%0d expected=%0d", rd_addr, cur_addr);
      end
      if (stim.size() > 0) rd_data <= stim.pop_front();
      else rd_data <= 8'h00;
    end else begin
      rd_ack <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (cmd_req && !cmd_ack) begin
      cmd_ack <= 1'b1;
      cmd_cnt++;
    end else begin
      cmd_ack <= 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(result == e.code, {e.tag, " result"}, result, e.code);
        chk(rd_cnt == e.reads, {e.tag, " reads"}, rd_cnt, e.reads);
        chk(cmd_cnt == e.cmds, {e.tag, " R8 cmds"}, cmd_cnt, e.cmds);
      end
      rd_cnt  = 0;
      cmd_cnt = 0;
    end
  end

  task automatic run(input bit md, input bit roe, input logic [AW-1:0] a,
                     input logic [2:0] code, input int reads, input int cmds,
                     input string tag, input bit poke);
    exp_t e;
    e.code = code; e.reads = reads; e.cmds = cmds; e.tag = tag;
    expq.push_back(e);
    cur_addr = a;
    @(negedge clk);
    mode = md; reset_on_error = roe; poll_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      mode = ~md; reset_on_error = ~roe; poll_addr = ~a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy,   "R1 busy",   busy, 0);
    chk(!done,   "R1 done",   done, 0);
    chk(!rd_req, "R1 rd_req", rd_req, 0);
    chk(!cmd_req && result == 3'd0, "R1 cmd/result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: stable bit 6
    stim.push_back(mk(0,0,0)); stim.push_back(mk(0,0,1));
    run(0, 1, 20'h12345, 3'd1, 2, 0, "R3 settled", 0);

    // R4: toggled, bit5 clear, then settled
    stim.push_back(mk(0,0,0)); stim.push_back(mk(1,0,0));
    stim.push_back(mk(1,0,0)); stim.push_back(mk(1,0,0));
    run(0, 1, 20'h00100, 3'd1, 4, 0, "R4 repoll", 0);

    // R5: bit5 set, recheck still toggles, reset command issued
    stim.push_back(mk(0,0,0)); stim.push_back(mk(1,1,0));
    stim.push_back(mk(0,1,0)); stim.push_back(mk(1,1,0));
    run(0, 1, 20'h0ABCD, 3'd2, 4, 1, "R5 device timeout", 0);

    // R8: same without reset_on_error
    stim.push_back(mk(1,0,0)); stim.push_back(mk(0,1,0));
    stim.push_back(mk(1,1,0)); stim.push_back(mk(0,1,0));
    run(0, 0, 20'h0ABCD, 3'd2, 4, 0, "R8 no cmd", 0);

    // R5: toggling stops as bit5 rises
    stim.push_back(mk(0,0,0)); stim.push_back(mk(1,1,0));
    stim.push_back(mk(1,1,0)); stim.push_back(mk(1,1,0));
    run(0, 1, 20'h00777, 3'd1, 4, 0, "R5 recheck complete", 0);

    // R6: suspend path, bit 6 toggling has no effect
    stim.push_back(mk(0,0,0)); stim.push_back(mk(1,0,1));
    run(1, 1, 20'h40000, 3'd4, 2, 0, "R6 suspended", 0);
    stim.push_back(mk(0,0,1)); stim.push_back(mk(1,1,1));
    run(1, 1, 20'h40000, 3'd5, 2, 0, "R6 not suspended", 0);

    // R7: never settles, bit 5 clear
    for (int i = 0; i < MP; i++) begin
      stim.push_back(mk(0,0,0)); stim.push_back(mk(1,0,0));
    end
    run(0, 1, 20'h05555, 3'd3, 2*MP, 1, "R7 host timeout", 0);

    // R10: start while busy ignored (status path, settles after two pairs)
    stim.push_back(mk(1,0,0)); stim.push_back(mk(0,0,0));
    stim.push_back(mk(0,0,0)); stim.push_back(mk(0,0,0));
    run(0, 0, 20'h03030, 3'd1, 4, 0, "R10 start ignored", 1);
    chk(done_cnt == 9, "R10 done count", done_cnt, 9);

    // R9: result held while idle, no further reads
    repeat (10) @(negedge clk);
    chk(result == 3'd1, "R9 result held", result, 1);
    chk(!rd_req && !busy, "R2 idle no read", rd_req, 0);
    chk(done_cnt == 9, "R9 no extra done", done_cnt, 9);
    chk(stim.size() == 0, "R2 all bytes consumed", stim.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule